// File: doc/BRIEF.md
# Command-Tagged Transmit Word Queue

This block is a short queue placed between a processor-facing register pair and a serial frame encoder. Software first writes a 4-bit command value, which stays in a holding register until it is written again. Each later write of an 8-bit data byte forms a 12-bit word from the held command and the byte, and puts that word into the entry slot of a three-slot queue. Words move toward the output slot one slot per clock. The encoder sees the word in the output slot together with a valid flag, and takes it with a one-cycle take strobe.

Two status flags show the queue state. The empty flag means no slot holds a word, including slots that a word is still moving through. The full flag means all three slots are occupied. A data write while the queue is full, with no take in the same cycle, replaces the newest word in the entry slot. It does not stall and it is not dropped, so the replaced word is lost. A write and a take in the same cycle both take effect.

Top module: `txq_word_fifo`

## Requirements
- R1: A synchronous active-low reset empties every slot, sets the empty flag to 1, and clears the full flag and the output valid flag to 0. It also clears the held command to 0, so a data write made before any command write carries command bits 0000.
- R2: Each queued word carries the held command in bits [11:8] and the data byte in bits [7:0].
- R3: The held command keeps its value until the next command write. A command write on its own adds nothing to the queue. A command write and a data write in the same cycle tag that word with the new command.
- R4: The empty flag is 0 from the clock edge that takes a data write. A word written into an empty queue reaches the output slot, and sets the output valid flag, on the second clock edge after the write edge.
- R5: Words reach the encoder in the order they were written. Each word is presented exactly once.
- R6: The full flag is 1 after three data writes with no take in between, and never while the empty flag is 1.
- R7: A data write while full with no take replaces the entry-slot word. The two older words are kept and the full flag stays 1.
- R8: A take while full, with no write, clears the full flag at that clock edge.
- R9: The empty flag returns to 1 at the edge where the last word is taken. A take while the output valid flag is 0 has no effect.
- R10: A data write and a take in the same cycle are both honoured, so a full queue stays full.
- R11: While the output valid flag is 1 and no take is given, the output word stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_i | input | 4 | Command value to hold |
| data_wr_i | input | 1 | Data write strobe; queues one word |
| data_i | input | 8 | Data byte |
| take_i | input | 1 | Encoder takes the output-slot word |
| word_o | output | 12 | Output-slot word {command, data} |
| word_valid_o | output | 1 | Output slot holds a word |
| empty_o | output | 1 | No slot holds a word |
| full_o | output | 1 | All slots hold words |

## Verification
All state changes at a clock edge. Flag updates caused by a write or a take can be seen right after that edge, and a word written into an empty queue is presented two edges after its write. The bench changes inputs 1 ns after each rising edge and reads the flags in that same window, so each flag check looks at the state the previous edge produced. A scoreboard monitor compares the presented word at the falling edge of every cycle in which a take is driven while the output valid flag is 1. An overwrite in the reference queue replaces its newest entry, the same way the design replaces its entry slot.

// File: rtl/txq_pkg.sv
// Package: shared defaults and slot action encoding for the transmit word queue.
// Assumes: all users take widths as parameters and use these values only as defaults.
package txq_pkg;
    localparam int unsigned TXQ_CMD_W  = 4;
    localparam int unsigned TXQ_DATA_W = 8;
    localparam int unsigned TXQ_DEPTH  = 3;

    // What a slot does at the next edge
    typedef enum logic [1:0] {
        SLOT_HOLD  = 2'd0,   // keep present contents
        SLOT_SHIFT = 2'd1,   // take upstream contents (or become free)
        SLOT_LOAD  = 2'd2    // take a freshly written word (entry slot only)
    } slot_act_e;
endpackage

// File: rtl/txq_cmd_latch.sv
// Module: holds the command tag written by software and provides the tag for
// the current data write. Same-cycle command writes pass through to the tag.
// Assumes: synchronous active-low reset clears the tag to zero.
module txq_cmd_latch #(
    parameter int unsigned CMD_W = txq_pkg::TXQ_CMD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_in,
    output logic [CMD_W-1:0] cmd_eff
);
    logic [CMD_W-1:0] cmd_q;

    // Register the tag on each command write
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (cmd_wr) cmd_q <= cmd_in;
    end

    // Present the new tag in the cycle it is written
    always_comb begin
        cmd_eff = cmd_wr ? cmd_in : cmd_q;
    end
endmodule

// File: rtl/txq_free_chain.sv
// Module: works out, from the output end backwards, which slots can accept a
// word at the next edge. A slot can accept if it is empty or its word moves on.
// Assumes: take is honoured only when the output slot holds a word.
module txq_free_chain #(
    parameter int unsigned DEPTH = txq_pkg::TXQ_DEPTH
) (
    input  logic [DEPTH-1:0] valid,
    input  logic             take,
    output logic [DEPTH-1:0] can_accept,
    output logic             take_eff
);
    // Qualify the encoder's take with the output slot occupancy
    always_comb begin
        take_eff = take && valid[DEPTH-1];
    end

    // Ripple the free condition from output slot to entry slot
    always_comb begin
        logic downstream_free;
        downstream_free = take_eff;
        can_accept      = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            downstream_free = !valid[k] || downstream_free;
            can_accept[k]   = downstream_free;
        end
    end
endmodule

// File: rtl/txq_slot_chain.sv
// Module: storage for the queue slots. Slot 0 is the entry, slot DEPTH-1 the
// output. Words move one slot per clock when the next slot can accept.
// A write always lands in slot 0, replacing it if it cannot drain.
// Assumes: can_accept comes from txq_free_chain for the same valid vector.
module txq_slot_chain
    import txq_pkg::*;
#(
    parameter int unsigned DEPTH  = TXQ_DEPTH,
    parameter int unsigned WORD_W = TXQ_CMD_W + TXQ_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [DEPTH-1:0]  can_accept,
    output logic [DEPTH-1:0]  valid,
    output logic [WORD_W-1:0] out_word
);
    logic [WORD_W-1:0] slot_q [DEPTH];
    slot_act_e         act    [DEPTH];

    // Choose each slot's action for the next edge
    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            if (k == 0 && wr)        act[k] = SLOT_LOAD;
            else if (can_accept[k])  act[k] = SLOT_SHIFT;
            else                     act[k] = SLOT_HOLD;
        end
    end

    // Update all slots together according to the chosen actions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            for (int k = 0; k < DEPTH; k++) slot_q[k] <= '0;
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                case (act[k])
                    SLOT_LOAD: begin
                        valid[k]  <= 1'b1;
                        slot_q[k] <= wr_word;
                    end
                    SLOT_SHIFT: begin
                        if (k == 0) begin
                            valid[k] <= 1'b0;
                        end else begin
                            valid[k]  <= valid[k-1];
                            slot_q[k] <= slot_q[k-1];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Output slot contents
    always_comb begin
        out_word = slot_q[DEPTH-1];
    end
endmodule

// File: rtl/txq_word_fifo.sv
// Module: top of the command-tagged transmit word queue. Forms {command, data}
// words, queues them in DEPTH fall-through slots, and gives empty and full flags.
// Assumes: one encoder take per presented word; take while not valid is ignored.
module txq_word_fifo #(
    parameter int unsigned CMD_W  = txq_pkg::TXQ_CMD_W,
    parameter int unsigned DATA_W = txq_pkg::TXQ_DATA_W,
    parameter int unsigned DEPTH  = txq_pkg::TXQ_DEPTH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_wr_i,
    input  logic [CMD_W-1:0]        cmd_i,
    input  logic                    data_wr_i,
    input  logic [DATA_W-1:0]       data_i,
    input  logic                    take_i,
    output logic [CMD_W+DATA_W-1:0] word_o,
    output logic                    word_valid_o,
    output logic                    empty_o,
    output logic                    full_o
);
    localparam int unsigned WORD_W = CMD_W + DATA_W;

    logic [CMD_W-1:0]  cmd_tag;
    logic [WORD_W-1:0] new_word;
    logic [DEPTH-1:0]  slot_valid;
    logic [DEPTH-1:0]  can_accept;
    logic              take_eff;

    txq_cmd_latch #(.CMD_W(CMD_W)) u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_wr (cmd_wr_i),
        .cmd_in (cmd_i),
        .cmd_eff(cmd_tag)
    );

    // Build the queued word: tag in the upper bits, data byte in the lower
    always_comb begin
        new_word = {cmd_tag, data_i};
    end

    txq_free_chain #(.DEPTH(DEPTH)) u_free (
        .valid     (slot_valid),
        .take      (take_i),
        .can_accept(can_accept),
        .take_eff  (take_eff)
    );

    txq_slot_chain #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (data_wr_i),
        .wr_word   (new_word),
        .can_accept(can_accept),
        .valid     (slot_valid),
        .out_word  (word_o)
    );

    // Status flags from slot occupancy
    always_comb begin
        word_valid_o = slot_valid[DEPTH-1];
        empty_o      = ~|slot_valid;
        full_o       = &slot_valid;
    end
endmodule

// Checker: temporal properties of the queue observed at its ports.
// Assumes: reset is synchronous and active low.
module txq_word_fifo_chk #(
    parameter int unsigned WORD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              data_wr_i,
    input logic              take_i,
    input logic [WORD_W-1:0] word_o,
    input logic              word_valid_o,
    input logic              empty_o,
    input logic              full_o
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (empty_o && !full_o && !word_valid_o));

    a_r6_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !empty_o);

    a_r4_valid_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> !empty_o);

    a_r7_overwrite_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && data_wr_i && !take_i) |=> full_o);

    a_r8_take_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && take_i && !data_wr_i) |=> !full_o);

    a_r9_idle_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !data_wr_i) |=> (empty_o && !word_valid_o));

    a_r10_write_take_balance: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && data_wr_i && take_i) |=> full_o);

    a_r11_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_o && !take_i) |=> (word_valid_o && $stable(word_o)));
endmodule

bind txq_word_fifo txq_word_fifo_chk #(.WORD_W(CMD_W + DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_wr_i   (data_wr_i),
    .take_i      (take_i),
    .word_o      (word_o),
    .word_valid_o(word_valid_o),
    .empty_o     (empty_o),
    .full_o      (full_o)
);

// File: tb/txq_word_fifo_test.sv
`timescale 1ns/1ps
// Bench: scoreboard for the transmit word queue. The driver task keeps a
// reference queue of expected words; the monitor compares presented words.
module txq_word_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr_i = 1'b0;
    logic [3:0]  cmd_i = '0;
    logic        data_wr_i = 1'b0;
    logic [7:0]  data_i = '0;
    logic        take_i = 1'b0;
    logic [11:0] word_o;
    logic        word_valid_o, empty_o, full_o;

    int          n_checks = 0;
    int          n_fails  = 0;
    bit          done     = 1'b0;
    logic [11:0] sb [$];
    logic [3:0]  cmd_model = '0;
    int          model_cnt = 0;

    always #4 clk = ~clk;   // 125 MHz

    txq_word_fifo uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr_i), .cmd_i(cmd_i),
        .data_wr_i(data_wr_i), .data_i(data_i), .take_i(take_i),
        .word_o(word_o), .word_valid_o(word_valid_o),
        .empty_o(empty_o), .full_o(full_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and update the reference queue
    task automatic step(input logic w, input logic cw, input logic [3:0] c,
                        input logic [7:0] d, input logic p);
        logic        popeff;
        logic [11:0] wd;
        popeff    = p && word_valid_o;
        data_wr_i = w; cmd_wr_i = cw; cmd_i = c; data_i = d; take_i = p;
        if (cw) cmd_model = c;
        if (w) begin
            wd = {cmd_model, d};
            if (model_cnt == 3 && !popeff) sb[sb.size()-1] = wd;
            else begin sb.push_back(wd); model_cnt++; end
        end
        if (popeff) model_cnt--;
        @(posedge clk); #1;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 4'h0, 8'h00, 1'b0);
    endtask

    // Monitor: compare each taken word with the reference queue (R5 order, R7 overwrite)
    always @(negedge clk) begin
        if (rst_n && take_i && word_valid_o) begin
            if (sb.size() == 0) check(1'b0, "R5 unexpected word", 32'(word_o), 32'h0);
            else begin
                logic [11:0] e;
                e = sb.pop_front();
                check(word_o == e, "R5/R7 word order", 32'(word_o), 32'(e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [11:0] held;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        check(empty_o == 1'b1, "R1 empty after reset", 32'(empty_o), 1);
        check(full_o == 1'b0, "R1 full after reset", 32'(full_o), 0);
        check(word_valid_o == 1'b0, "R1 valid after reset", 32'(word_valid_o), 0);

        // Single word into empty queue, default command
        step(1'b1, 1'b0, 4'h0, 8'h5A, 1'b0);
        check(empty_o == 1'b0, "R4 empty drops at write edge", 32'(empty_o), 0);
        check(word_valid_o == 1'b0, "R4 not valid after 0 edges", 32'(word_valid_o), 0);
        idle();
        check(word_valid_o == 1'b0, "R4 not valid after 1 edge", 32'(word_valid_o), 0);
        idle();
        check(word_valid_o == 1'b1, "R4 valid after 2 edges", 32'(word_valid_o), 1);
        check(word_o == 12'h05A, "R1/R2 word format and zero command", 32'(word_o), 32'h05A);
        step(1'b0, 1'b0, 4'h0, 8'h00, 1'b1);
        check(empty_o == 1'b1, "R9 empty after last take", 32'(empty_o), 1);

        // Command alone queues nothing
        step(1'b0, 1'b1, 4'hC, 8'h00, 1'b0);
        check(empty_o == 1'b1, "R3 command write queues nothing", 32'(empty_o), 1);
        step(1'b1, 1'b0, 4'h0, 8'h11, 1'b0);
        step(1'b1, 1'b0, 4'h0, 8'h22, 1'b0);
        check(full_o == 1'b0, "R6 not full after two writes", 32'(full_o), 0);
        step(1'b1, 1'b1, 4'h3, 8'h33, 1'b0);
        check(full_o == 1'b1, "R6 full after three writes", 32'(full_o), 1);
        step(1'b1, 1'b0, 4'h0, 8'h44, 1'b0);
        check(full_o == 1'b1, "R7 full kept on overwrite", 32'(full_o), 1);
        idle();
        held = word_o;
        check(word_o == 12'hC11 && word_valid_o, "R3 sticky command on first word", 32'(word_o), 32'hC11);
        idle(); idle();
        check(word_o == held && word_valid_o, "R11 word held without take", 32'(word_o), 32'(held));
        step(1'b1, 1'b0, 4'h0, 8'h55, 1'b1);
        check(full_o == 1'b1, "R10 write with take keeps full", 32'(full_o), 1);
        step(1'b0, 1'b0, 4'h0, 8'h00, 1'b1);
        check(full_o == 1'b0, "R8 take clears full", 32'(full_o), 0);
        for (int i = 0; i < 12 && sb.size() > 0; i++) step(1'b0, 1'b0, 4'h0, 8'h00, 1'b1);
        check(empty_o == 1'b1, "R9 empty after drain", 32'(empty_o), 1);
        step(1'b0, 1'b0, 4'h0, 8'h00, 1'b1);
        check(empty_o && !word_valid_o && !full_o, "R9 take on empty ignored",
              32'({empty_o, word_valid_o, full_o}), 32'b100);

        // Sticky command survives an empty period
        step(1'b1, 1'b0, 4'h0, 8'h66, 1'b0);
        idle(); idle();
        check(word_o == 12'h366, "R3 command kept across idle", 32'(word_o), 32'h366);
        step(1'b0, 1'b0, 4'h0, 8'h00, 1'b1);

        // Mixed stream of writes, command changes and takes
        for (int i = 0; i < 40; i++)
            step((i % 4) != 3, (i % 5) == 0, 4'(i), 8'(i * 7 + 1), (i % 3) != 1);
        for (int i = 0; i < 12 && sb.size() > 0; i++) step(1'b0, 1'b0, 4'h0, 8'h00, 1'b1);
        idle();
        check(sb.size() == 0, "R5 every word delivered", 32'(sb.size()), 0);
        check(empty_o == 1'b1, "R9 empty at end", 32'(empty_o), 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule